// File: doc/BRIEF.md
# Pseudo-Random Noise Voice

This block produces the one-bit noise voice of a four-voice programmable sound generator. A 15-bit shift register with linear feedback makes the noise. Each shift moves the register one place toward its least significant bit. The new top bit comes from a feedback function, and the bit that arrives in position zero is the audio output. A three-bit control word selects the shift rate and the feedback type. The shift rate is either a fixed divider of the system clock or the rising edges of the third tone voice's square wave. The feedback type is either broadband white noise or a short repeating buzz, called periodic noise.

The host writes the control word with a one-cycle strobe. The new word takes effect at once, with no busy or ready handshake. Each write also reseeds the register with a single one in its top bit. A white-noise register can therefore never reach the all-zero state, in which it would stop changing. The write also restarts the fixed-rate prescaler, so the first shift after a write falls a known number of cycles later. All pins are plain control or status pins: the block has no data stream, so it needs no valid/ready handshake.

Top module: `psg_noise_voice`

## Requirements
- R1: After a synchronous reset, `noise_o` is 0. The register holds only its top bit set, and the control word is 3'b000: rate setting 0 with periodic feedback.
- R2: The control word encodes its fields as follows. Bits [1:0] select the rate: 0 is 2^DIV_LOG2 cycles, 1 is 2^(DIV_LOG2+1), 2 is 2^(DIV_LOG2+2), and 3 is the tone-3 input. Bit [2] set selects white feedback and clear selects periodic feedback.
- R3: With a fixed rate of N cycles, the register shifts once every N clock edges. The first shift falls on the Nth edge after the edge that sampled the write.
- R4: With rate setting 3, the register shifts on each clock edge that samples `tone3_i` high when the previous edge sampled it low. While `tone3_i` stays high, no further shift happens.
- R5: The clock edge that samples `ctrl_we_i` high loads the control word and reseeds the register to only its top bit set. This reseed wins over a shift due on that same edge, and `noise_o` is 0 immediately after it.
- R6: In white mode, the new top bit is the XOR of register bits 0 and 1, and the register never holds all zeros.
- R7: In periodic mode, the new top bit is the bit shifted out of position 0. After a reseed, `noise_o` first rises after exactly 14 shifts and then repeats every 15 shifts.
- R8: In the fixed-rate settings, activity on `tone3_i` has no effect on `noise_o`.
- R9: `noise_o` is always bit 0 of the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single-phase system clock |
| rst | input | 1 | Synchronous reset, active high |
| ctrl_we_i | input | 1 | One-cycle write strobe for the control word |
| ctrl_i | input | 3 | Control word: bit 2 is white/periodic, bits 1:0 are the rate |
| tone3_i | input | 1 | Square-wave output of the third tone voice |
| noise_o | output | 1 | Noise bit (register bit 0) |

## Verification
A control write and a shift can fall on the same clock edge, so that a reseed meets a shift that is due. The bench provokes this by issuing a write exactly N edges after the previous write, the edge on which the fixed prescaler's shift is due. It also sweeps writes across the tone-3 edges. The bench's arithmetic model lets the reseed override the shift, and every later output bit is compared against that model, so an ordering error appears as a diverged sequence.

// File: rtl/psg_noise_pkg.sv
package psg_noise_pkg;

  localparam int CTRL_W = 3;

  typedef enum logic [1:0] {
    RATE_DIV0 = 2'd0,
    RATE_DIV1 = 2'd1,
    RATE_DIV2 = 2'd2,
    RATE_TONE = 2'd3
  } rate_sel_e;

  typedef struct packed {
    logic      white;
    rate_sel_e rate;
  } noise_ctrl_t;

endpackage

// File: rtl/noise_prescaler.sv
module noise_prescaler #(
  parameter int DIV_LOG2 = 9
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       clr,
  output logic [2:0] tick
);
  localparam int CNT_W = DIV_LOG2 + 2;

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else            cnt <= cnt + 1'b1;
  end

  // tap k fires on the last cycle of each 2^(DIV_LOG2+k) window
  for (genvar k = 0; k < 3; k++) begin : g_tap
    assign tick[k] = &cnt[DIV_LOG2+k-1:0];
  end

  // the slower windows are nested inside the faster ones
  p_nested_ticks_r3: assert property (@(posedge clk) disable iff (rst)
    tick[2] |-> (tick[1] && tick[0]));

  // the fastest window never fires twice in a row
  p_tick_spacing_r3: assert property (@(posedge clk) disable iff (rst)
    (tick[0] && !clr) |=> !tick[0]);

endmodule

// File: rtl/noise_rate_sel.sv
module noise_rate_sel
  import psg_noise_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  rate_sel_e rate,
  input  logic [2:0] tick,
  input  logic      tone_i,
  output logic      shift_en
);
  logic tone_q;

  always_ff @(posedge clk) begin
    if (rst) tone_q <= 1'b0;
    else     tone_q <= tone_i;
  end

  always_comb begin
    unique case (rate)
      RATE_DIV0: shift_en = tick[0];
      RATE_DIV1: shift_en = tick[1];
      RATE_DIV2: shift_en = tick[2];
      default:   shift_en = tone_i & ~tone_q;
    endcase
  end

  // tone-driven shifts come from rising edges, never on back-to-back cycles
  p_tone_edge_gap_r4: assert property (@(posedge clk) disable iff (rst)
    (rate == RATE_TONE && shift_en && $stable(rate)) |=> !(shift_en && rate == RATE_TONE));

endmodule

// File: rtl/noise_lfsr.sv
module noise_lfsr #(
  parameter int WIDTH = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             shift,
  input  logic             white,
  output logic [WIDTH-1:0] state
);
  localparam logic [WIDTH-1:0] SEED = {1'b1, {(WIDTH-1){1'b0}}};

  logic fb;

  always_comb fb = white ? (state[0] ^ state[1]) : state[0];

  always_ff @(posedge clk) begin
    if (rst || load) state <= SEED;
    else if (shift)  state <= {fb, state[WIDTH-1:1]};
  end

  p_reseed_wins_r5: assert property (@(posedge clk) disable iff (rst)
    load |=> (state == SEED));

  p_never_zero_r6: assert property (@(posedge clk) disable iff (rst)
    state != '0);

  p_shift_moves_r3: assert property (@(posedge clk) disable iff (rst)
    (!load && shift) |=> (state[WIDTH-2:0] == $past(state[WIDTH-1:1])));

  p_periodic_rotates_r7: assert property (@(posedge clk) disable iff (rst)
    (!load && shift && !white) |=> (state[WIDTH-1] == $past(state[0])));

  p_idle_holds_r8: assert property (@(posedge clk) disable iff (rst)
    (!load && !shift) |=> $stable(state));

endmodule

// File: rtl/psg_noise_voice.sv
module psg_noise_voice
  import psg_noise_pkg::*;
#(
  parameter int DIV_LOG2 = 9,
  parameter int LFSR_W   = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctrl_we_i,
  input  logic [CTRL_W-1:0] ctrl_i,
  input  logic              tone3_i,
  output logic              noise_o
);
  noise_ctrl_t       ctrl_q;
  logic [2:0]        tick;
  logic              shift_en;
  logic [LFSR_W-1:0] state;

  always_ff @(posedge clk) begin
    if (rst)            ctrl_q <= '{white: 1'b0, rate: RATE_DIV0};
    else if (ctrl_we_i) ctrl_q <= noise_ctrl_t'(ctrl_i);
  end

  noise_prescaler #(.DIV_LOG2(DIV_LOG2)) u_pre (
    .clk  (clk),
    .rst  (rst),
    .clr  (ctrl_we_i),
    .tick (tick)
  );

  noise_rate_sel u_sel (
    .clk      (clk),
    .rst      (rst),
    .rate     (ctrl_q.rate),
    .tick     (tick),
    .tone_i   (tone3_i),
    .shift_en (shift_en)
  );

  noise_lfsr #(.WIDTH(LFSR_W)) u_lfsr (
    .clk   (clk),
    .rst   (rst),
    .load  (ctrl_we_i),
    .shift (shift_en),
    .white (ctrl_q.white),
    .state (state)
  );

  assign noise_o = state[0];

  p_write_clears_out_r5: assert property (@(posedge clk) disable iff (rst)
    ctrl_we_i |=> !noise_o);

  p_ctrl_loaded_r2: assert property (@(posedge clk) disable iff (rst)
    ctrl_we_i |=> (ctrl_q == noise_ctrl_t'($past(ctrl_i))));

endmodule

// File: tb/sim_psg_noise_voice.sv
module sim_psg_noise_voice;
  localparam int DL   = 2;
  localparam int W    = 15;
  localparam int N0   = 1 << DL;
  localparam int CMOD = N0 * 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       we  = 1'b0;
  logic [2:0] cw  = 3'd0;
  logic       tone = 1'b0;
  logic       noise;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  // model state
  logic [W-1:0] m_reg;
  logic [2:0]   m_ctrl;
  int           m_cnt;
  logic         m_tq;
  int           lcg = 12345;

  always #2 clk = ~clk;

  psg_noise_voice #(.DIV_LOG2(DL), .LFSR_W(W)) u0 (
    .clk(clk), .rst(rst), .ctrl_we_i(we), .ctrl_i(cw),
    .tone3_i(tone), .noise_o(noise)
  );

  task automatic check(input string req, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s t=%0t got %0d expected %0d", req, $time, got, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  // one clock: drive at negedge, update model at posedge, compare at next negedge
  task automatic step(input string req, input logic w, input logic [2:0] d, input logic t);
    logic sh;
    int   n;
    we = w; cw = d; tone = t;
    @(posedge clk);
    n = N0 << m_ctrl[1:0];
    if (m_ctrl[1:0] == 2'd3) sh = t && !m_tq;
    else                     sh = ((m_cnt % n) == n - 1);
    if (w) begin
      m_reg  = {1'b1, {(W-1){1'b0}}};
      m_ctrl = d;
      m_cnt  = 0;
    end else begin
      if (sh) m_reg = {(m_ctrl[2] ? (m_reg[0] ^ m_reg[1]) : m_reg[0]), m_reg[W-1:1]};
      m_cnt = (m_cnt + 1) % CMOD;
    end
    m_tq = t;
    @(negedge clk);
    check(req, int'(noise), int'(m_reg[0]));
  endtask

  function automatic logic next_tone(input int mode);
    lcg = (lcg * 1103515245 + 12345) & 32'h7fffffff;
    return logic'((lcg >> 16) & 1);
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin : stim
    int first_hi;
    m_reg  = {1'b1, {(W-1){1'b0}}};
    m_ctrl = 3'd0; m_cnt = 0; m_tq = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check("R1", int'(noise), 0);

    // R1 / R3 / R7: default control after reset, first rise after 14 shifts
    first_hi = -1;
    for (int i = 1; i <= 20 * N0; i++) begin
      step("R1", 1'b0, 3'd0, 1'b0);
      if (noise && first_hi < 0) first_hi = i;
    end
    check("R7", first_hi, 14 * N0);

    // R2/R3/R4/R6/R7/R8 sweep of every control word with random tone activity
    for (int c = 0; c < 8; c++) begin
      string tag;
      int n;
      n = (c[1:0] == 2'd3) ? 2 : (N0 << c[1:0]);
      tag = (c[1:0] == 2'd3) ? "R4" : (c[2] ? "R6" : "R8");
      step("R2", 1'b1, c[2:0], tone);
      for (int i = 0; i < 40 * n; i++) step(tag, 1'b0, c[2:0], next_tone(c));
    end

    // R7: periodic mode repeats every 15 shifts, tone-driven
    step("R7", 1'b1, 3'b011, 1'b0);
    for (int i = 0; i < 15 * 6; i++) begin
      step("R7", 1'b0, 3'b011, 1'b1);
      step("R9", 1'b0, 3'b011, 1'b0);
    end

    // R5: rewrite exactly on the edge where a fixed-rate shift is due
    for (int k = 0; k < 3; k++) begin
      int n;
      n = N0 << k;
      step("R5", 1'b1, {1'b1, 2'(k)}, 1'b0);
      for (int r = 0; r < 5; r++) begin
        for (int i = 0; i < n - 1; i++) step("R3", 1'b0, {1'b1, 2'(k)}, 1'b0);
        step("R5", 1'b1, {1'b1, 2'(k)}, 1'b0);
        check("R5", int'(noise), 0);
      end
    end

    // R5: write landing on a tone rising edge
    step("R5", 1'b1, 3'b111, 1'b0);
    for (int i = 0; i < 20; i++) step("R4", 1'b0, 3'b111, i[0]);
    step("R5", 1'b1, 3'b111, 1'b1);
    check("R5", int'(noise), 0);

    // R6: long white run clocked by tone edges
    step("R6", 1'b1, 3'b111, 1'b0);
    for (int i = 0; i < 70000; i++) step("R6", 1'b0, 3'b111, i[0]);

    done = 1;
    summary();
    $finish;
  end
endmodule